// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This engine watches a byte stream headed to or from a NAND sector and folds every set data bit into two 12-bit parity halves. One half gathers the bit addresses of the set bits. The other gathers the complements of those addresses. The packed, inverted 24-bit result is the code that goes into the spare area on a write.

On a read, the code stored in flash is presented with a compare request. The engine XORs it with the freshly computed code and classifies the difference. The result is one of four outcomes: clean, a single data-bit error that can be fixed, a single flipped bit inside the stored code, or an uncorrectable pattern. For a fixable error it also reports the byte offset and the bit mask to apply.

A compare consumes the accumulated code and starts a fresh accumulation. A restart pulse also starts a fresh accumulation, at any time.

Top module: `nand_ecc1_top`

## Requirements
- R1: For each set bit of an accepted byte, take the bit address a = byteIndex*8 + bitIndex (12 bits at the default 512-byte sector). The upper parity half is XORed with a, and the lower half is XORed with ~a.
- R2: `eccCode` is the bitwise inverse of {upper half, lower half}. The lower half sits in bits 11:0 and the upper half in bits 23:12. A sector of all 0xFF bytes therefore gives 24'hFFFFFF.
- R3: A byte with `byteValid` low has no effect on the code and does not advance the byte index.
- R4: A byte accepted with `sectorStart` high takes byte index 0. Each later accepted byte takes the next index.
- R5: `restart` zeroes both halves and the byte index, so `eccCode` reads 24'hFFFFFF on the next cycle.
- R6: On a compare, if `cmpCode` equals `eccCode`, the status is clean (2'd0).
- R7: If the difference d = eccCode ^ cmpCode has d[23:12] ^ d[11:0] == 12'hFFF, the status is corrected (2'd1). `errByte` = d[23:15] and `errMask` = 1 << d[14:12].
- R8: In the case of R7, if d[23:15] is not below `SECTOR_BYTES`, the status is uncorrectable (2'd3).
- R9: Otherwise, a difference with exactly one set bit gives status code-error (2'd2). In that case `errByte` and `errMask` are zero.
- R10: Any other nonzero difference gives status uncorrectable (2'd3), with `errByte` and `errMask` zero.
- R11: Results appear in the cycle after `cmpReq`, together with a one-cycle `cmpDone` pulse. They hold until the next request. The compare also clears the accumulation, so `eccCode` reads 24'hFFFFFF afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Data byte present this cycle |
| byteData | input | 8 | Data byte |
| sectorStart | input | 1 | Current byte is sector byte 0 |
| restart | input | 1 | Clear the accumulation |
| cmpReq | input | 1 | Compare request |
| cmpCode | input | 24 | Code read from flash |
| eccCode | output | 24 | Current code for writing |
| status | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| errByte | output | 9 | Byte offset to fix |
| errMask | output | 8 | Bit mask to XOR into that byte |
| cmpDone | output | 1 | Result valid pulse |

## Verification
The assertions assume that `restart` and `cmpReq` are single-cycle strobes. They also assume that a sector of data never crosses a compare. The bench keeps both strobes to one cycle and never raises them while a byte is valid.

A second instance with a 320-byte sector reaches the offset-out-of-range case. At the default size that case is unreachable.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_ERR = 2'd2,
    ECC_FATAL    = 2'd3
  } eccStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAcc;  // start a fresh accumulation
    logic accEn;     // fold the current byte in
    logic cmpLatch;  // evaluate and register the comparison
  } eccStrb_t;

endpackage

// File: rtl/nand_ecc1_ctrl.sv
module nand_ecc1_ctrl
  import nand_ecc1_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             sectorStart,
  input  logic             restart,
  input  logic             cmpReq,
  output eccStrb_t         strb,
  output logic [IDX_W-1:0] byteIdx
);

  logic [IDX_W-1:0] idxCnt;
  logic             clearNow;

  assign clearNow      = restart | cmpReq;
  assign strb.clearAcc = clearNow;
  assign strb.accEn    = byteValid;
  assign strb.cmpLatch = cmpReq;

  // index of the byte presented this cycle
  assign byteIdx = (sectorStart || clearNow) ? '0 : idxCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxCnt <= '0;
    end else if (byteValid) begin
      idxCnt <= byteIdx + 1'b1;
    end else if (clearNow) begin
      idxCnt <= '0;
    end
  end

  // R4: a sector-start byte restarts numbering, so the next index is 1
  p_start_index_r4: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && sectorStart && !clearNow) |=> (idxCnt == IDX_W'(1)));

  // R3: idle cycles leave the index untouched
  p_idle_index_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !clearNow) |=> $stable(idxCnt));

endmodule

// File: rtl/nand_ecc1_dp.sv
module nand_ecc1_dp
  import nand_ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int HALF_W       = 12,
  parameter int IDX_W        = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  eccStrb_t            strb,
  input  logic [IDX_W-1:0]    byteIdx,
  input  logic [7:0]          byteData,
  input  logic [2*HALF_W-1:0] cmpCode,
  output logic [2*HALF_W-1:0] eccCode,
  output logic [1:0]          status,
  output logic [IDX_W-1:0]    errByte,
  output logic [7:0]          errMask,
  output logic                cmpDone
);

  localparam int CODE_W = 2 * HALF_W;
  localparam logic [IDX_W:0] SECT_LIM = (IDX_W+1)'(SECTOR_BYTES);

  logic [HALF_W-1:0] upAcc, loAcc, upNext, loNext;

  // parity accumulation
  always_comb begin
    upNext = strb.clearAcc ? '0 : upAcc;
    loNext = strb.clearAcc ? '0 : loAcc;
    for (int i = 0; i < 8; i++) begin
      if (strb.accEn && byteData[i]) begin
        upNext = upNext ^ {byteIdx, 3'(i)};
        loNext = loNext ^ ~{byteIdx, 3'(i)};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upAcc <= '0;
      loAcc <= '0;
    end else begin
      upAcc <= upNext;
      loAcc <= loNext;
    end
  end

  assign eccCode = ~{upAcc, loAcc};

  // classification of the difference
  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] diffUp, diffLo;
  logic [IDX_W-1:0]  locByte;
  eccStatus_t        stNext;
  logic [IDX_W-1:0]  byteNext;
  logic [7:0]        maskNext;

  assign diff    = eccCode ^ cmpCode;
  assign diffUp  = diff[CODE_W-1:HALF_W];
  assign diffLo  = diff[HALF_W-1:0];
  assign locByte = diffUp[HALF_W-1:3];

  always_comb begin
    stNext   = ECC_FATAL;
    byteNext = '0;
    maskNext = '0;
    if (diff == '0) begin
      stNext = ECC_CLEAN;
    end else if ((diffUp ^ diffLo) == '1) begin
      if ({1'b0, locByte} < SECT_LIM) begin
        stNext   = ECC_FIXED;
        byteNext = locByte;
        maskNext = 8'(1) << diffUp[2:0];
      end
    end else if ($onehot(diff)) begin
      stNext = ECC_CODE_ERR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= ECC_CLEAN;
      errByte <= '0;
      errMask <= '0;
      cmpDone <= 1'b0;
    end else begin
      cmpDone <= strb.cmpLatch;
      if (strb.cmpLatch) begin
        status  <= stNext;
        errByte <= byteNext;
        errMask <= maskNext;
      end
    end
  end

  // R5: a clear with no byte leaves an empty code
  p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAcc && !strb.accEn) |=> (eccCode == '1));

  // R3: nothing accepted, nothing cleared, code unchanged
  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accEn && !strb.clearAcc) |=> $stable(eccCode));

  // R7: a fixable location has one mask bit and an in-range offset
  p_fix_loc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (status == ECC_FIXED) |-> ($onehot(errMask) && ({1'b0, errByte} < SECT_LIM)));

  // R9 / R10: other outcomes carry no location
  p_no_loc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (status != ECC_FIXED) |-> (errMask == '0 && errByte == '0));

  // R11: results hold between requests
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpLatch |=> ($stable(status) && $stable(errByte) && $stable(errMask) && !cmpDone));

endmodule

// File: rtl/nand_ecc1_top.sv
module nand_ecc1_top
  import nand_ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int HALF_W = $clog2(SECTOR_BYTES * 8),
  localparam int IDX_W  = HALF_W - 3,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              sectorStart,
  input  logic              restart,
  input  logic              cmpReq,
  input  logic [CODE_W-1:0] cmpCode,
  output logic [CODE_W-1:0] eccCode,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  errByte,
  output logic [7:0]        errMask,
  output logic              cmpDone
);

  eccStrb_t         strb;
  logic [IDX_W-1:0] byteIdx;

  nand_ecc1_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sectorStart(sectorStart),
    .restart(restart), .cmpReq(cmpReq), .strb(strb), .byteIdx(byteIdx)
  );

  nand_ecc1_dp #(.SECTOR_BYTES(SECTOR_BYTES), .HALF_W(HALF_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .byteData(byteData),
    .cmpCode(cmpCode), .eccCode(eccCode), .status(status), .errByte(errByte),
    .errMask(errMask), .cmpDone(cmpDone)
  );

endmodule

// File: tb/test_nand_ecc1_top.sv
`timescale 1ns/1ps
module test_nand_ecc1_top;

  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        sectorStart = 1'b0;
  logic        restart = 1'b0;
  logic        cmpReq = 1'b0;
  logic [23:0] cmpCode = '0;
  logic [23:0] eccCode, eccCodeS;
  logic [1:0]  status, statusS;
  logic [8:0]  errByte, errByteS;
  logic [7:0]  errMask, errMaskS;
  logic        cmpDone, cmpDoneS;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  nand_ecc1_top i_nand_ecc1_top (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .sectorStart(sectorStart), .restart(restart), .cmpReq(cmpReq), .cmpCode(cmpCode),
    .eccCode(eccCode), .status(status), .errByte(errByte), .errMask(errMask), .cmpDone(cmpDone)
  );

  nand_ecc1_top #(.SECTOR_BYTES(320)) i_nand_ecc1_top_small (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .sectorStart(sectorStart), .restart(restart), .cmpReq(cmpReq), .cmpCode(cmpCode),
    .eccCode(eccCodeS), .status(statusS), .errByte(errByteS), .errMask(errMaskS), .cmpDone(cmpDoneS)
  );

  typedef struct {
    logic [1:0] st;
    logic [8:0] b;
    logic [7:0] m;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] sect [NB];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expectations as results appear
  always @(negedge clk) begin
    if (rstN && cmpDone) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected cmpDone", 32'(cmpDone), 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(status == e.st, {e.tag, " status"}, 32'(status), 32'(e.st));
        check(errByte == e.b && errMask == e.m, {e.tag, " location"},
              {15'd0, errByte, errMask}, {15'd0, e.b, e.m});
      end
    end
  end

  function automatic logic [23:0] modelCode();
    logic [11:0] up, lo, a;
    up = '0; lo = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 8; i++)
        if (sect[b][i]) begin
          a  = 12'(b * 8 + i);
          up = up ^ a;
          lo = lo ^ ~a;
        end
    return ~{up, lo};
  endfunction

  // sends sect[], inserting idle cycles with junk data
  task automatic sendSector();
    for (int b = 0; b < NB; b++) begin
      if (b % 97 == 50) begin
        @(negedge clk);
        byteValid = 1'b0; byteData = 8'h5A; sectorStart = 1'b0;
      end
      @(negedge clk);
      byteValid = 1'b1; byteData = sect[b]; sectorStart = (b == 0);
    end
    @(negedge clk);
    byteValid = 1'b0; byteData = 8'h00; sectorStart = 1'b0;
  endtask

  task automatic doCmp(input logic [23:0] code, input logic [1:0] st,
                       input logic [8:0] b, input logic [7:0] m, input string tag);
    expItem_t e;
    @(negedge clk);
    cmpReq = 1'b1; cmpCode = code;
    e.st = st; e.b = b; e.m = m; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    cmpReq = 1'b0;
    @(negedge clk);
    check(eccCode == 24'hFFFFFF, "R11 compare clears code", 32'(eccCode), 32'hFFFFFF);
    check(!cmpDone, "R11 done is one pulse", 32'(cmpDone), 32'd0);
  endtask

  task automatic pulseRestart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(eccCode == 24'hFFFFFF, "R5 restart clears", 32'(eccCode), 32'hFFFFFF);
  endtask

  initial begin
    #(20ns * 200000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [23:0] storedA;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(eccCode == 24'hFFFFFF && status == 2'd0 && !cmpDone, "R2 reset state",
          32'(eccCode), 32'hFFFFFF);

    // pseudo-random sector
    lfsr = 16'hACE1;
    for (int b = 0; b < NB; b++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sect[b] = lfsr[7:0];
    end
    storedA = modelCode();
    sendSector();
    check(eccCode == storedA, "R1 R3 random sector code", 32'(eccCode), 32'(storedA));
    doCmp(storedA, 2'd0, 9'd0, 8'd0, "R6 clean compare");
    repeat (3) @(negedge clk);
    check(status == 2'd0 && !cmpDone, "R11 result held", 32'(status), 32'd0);

    // single data bit flip
    sect[37] = sect[37] ^ 8'h20;
    sendSector();
    doCmp(storedA, 2'd1, 9'd37, 8'h20, "R7 single data bit");
    repeat (3) @(negedge clk);
    check(status == 2'd1 && errByte == 9'd37 && errMask == 8'h20, "R11 fix held",
          {22'd0, status, errMask}, {22'd0, 2'd1, 8'h20});
    sect[37] = sect[37] ^ 8'h20;

    // stored code has one flipped bit
    sendSector();
    doCmp(storedA ^ 24'h000400, 2'd2, 9'd0, 8'd0, "R9 code-only error");

    // two data bits flipped
    sect[3]   = sect[3] ^ 8'h01;
    sect[300] = sect[300] ^ 8'h80;
    sendSector();
    doCmp(storedA, 2'd3, 9'd0, 8'd0, "R10 double error");

    // erased sector
    for (int b = 0; b < NB; b++) sect[b] = 8'hFF;
    sendSector();
    check(eccCode == 24'hFFFFFF, "R2 erased sector code", 32'(eccCode), 32'hFFFFFF);
    doCmp(24'hFFFFFF, 2'd0, 9'd0, 8'd0, "R6 erased clean");

    // restart mid-stream, then sector start resets the index
    @(negedge clk); byteValid = 1'b1; byteData = 8'h3C; sectorStart = 1'b1;
    @(negedge clk); byteValid = 1'b1; byteData = 8'hC3; sectorStart = 1'b0;
    @(negedge clk); byteValid = 1'b0;
    pulseRestart();
    @(negedge clk); byteValid = 1'b1; byteData = 8'h00; sectorStart = 1'b1;
    @(negedge clk); byteValid = 1'b1; byteData = 8'h00; sectorStart = 1'b0;
    @(negedge clk); byteValid = 1'b1; byteData = 8'h00;
    @(negedge clk); byteValid = 1'b1; byteData = 8'h01; sectorStart = 1'b1;
    @(negedge clk); byteValid = 1'b0; byteData = 8'hFF; sectorStart = 1'b0;
    check(eccCode == 24'hFFF000, "R4 sector start index zero", 32'(eccCode), 32'hFFF000);
    @(negedge clk);
    check(eccCode == 24'hFFF000, "R3 invalid byte ignored", 32'(eccCode), 32'hFFF000);

    // location at byte 400: fixable at 512, out of range at 320
    pulseRestart();
    doCmp(24'h37EC81, 2'd1, 9'd400, 8'h02, "R7 offset 400");
    check(statusS == 2'd3 && errMaskS == 8'd0, "R8 offset beyond sector",
          32'(statusS), 32'd3);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R11 all results seen", 32'(expQ.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule